// File: doc/BRIEF.md
# Framed Serial Register Access Port

This block is a slave serial port that moves 16-bit words, most significant bit first, over one serial clock. A host feeds it a receive data line and a receive frame-sync line. The block answers on its own transmit data and transmit frame-sync lines. Every host transfer is a pair of words: an address word, then a data word. In the address word, bit 15 selects read (1) or write (0), and bits 4..0 select one of 32 register slots. Slots 0 to 5 are control registers. Slot 6 is a converter input word and slot 7 is a filter input word; both are write-only. Slots 8 and 9 are device-side sample outputs, and slots 10 to 31 are reserved.

A host read of a control slot uses two words: a request word with bit 15 set, then any dummy word. When the dummy word ends, the block sends a reply pair, which is the slot's address word followed by the slot's contents. The device side can also hand the port a sample together with a select bit (0 means slot 8, 1 means slot 9). The port then sends that slot's address word followed by the sample. Outgoing address words carry zeros in bits 15..5. Receive lines are sampled on the falling clock edge. Transmit lines change on the rising edge.

Top module: `serial_regport`

## Requirements
- R1: After reset, sdo and sdofs are 0, and all control words, dac_word and filt_word are 0.
- R2: A write stores its data word into control slot 0..5 only once the data word's last bit has been received. After the address word alone, the slot still holds its old value. An address word framed after idle clocks still pairs with the next word.
- R3: A write to slot 6 updates dac_word and raises dac_stb for exactly one clock. A write to slot 7 does the same for filt_word and filt_stb.
- R4: A write to slot 8, 9 or 10..31 changes no output and starts no transmission.
- R5: A read request for control slot 0..5, followed by a dummy word, produces a reply pair: {11'b0, slot} and then the slot's stored value.
- R6: A read request for slot 6..31 produces no transmission.
- R7: A sample handed in with smp_vld produces a pair: address word 0x0008 (smp_sel=0) or 0x0009 (smp_sel=1), then the sample value.
- R8: A read reply that becomes pending while a pair is being sent waits until that whole pair has finished.
- R9: If a read reply and a buffered sample are both pending when the port goes idle, the reply is sent first. The buffer holds one sample, and a newer sample replaces an unsent older one.
- R10: While a word is being received, sdifs is ignored except during its last bit. sdifs high during the last bit starts the next word immediately.
- R11: sdofs is high for one clock before the first bit of an address word, and also during the address word's last bit, which frames the data word. It is low during every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Receive data, sampled on the falling edge |
| sdifs | input | 1 | Receive frame sync, sampled on the falling edge |
| sdo | output | 1 | Transmit data, driven on the rising edge |
| sdofs | output | 1 | Transmit frame sync, driven on the rising edge |
| smp_vld | input | 1 | Device sample present (rising edge) |
| smp_sel | input | 1 | Sample source: 0 for slot 8, 1 for slot 9 |
| smp_data | input | 16 | Sample value |
| ctrl_regs | output | 96 | Control slots, slot k in bits [16k+15:16k] |
| dac_word | output | 16 | Last word written to slot 6 |
| dac_stb | output | 1 | One-clock pulse on a slot-6 write |
| filt_word | output | 16 | Last word written to slot 7 |
| filt_stb | output | 1 | One-clock pulse on a slot-7 write |

## Verification
The bench builds the port with its default parameters: 16-bit words, 5 address bits and six control slots. With these values the whole 32-slot address space can be reached, so the bench can probe reserved and read-only slots as well as the edges of the control range. The bench drives words that are chained through the last-bit frame sync, words that are separated by idle clocks, and a frame sync raised in the middle of a word. It also overlaps a read request with an outgoing sample pair and with two further samples, which exercises the reply ordering and the replacement of a buffered sample.

// File: rtl/serial_regport.sv
module serial_regport #(
  parameter int W      = 16,
  parameter int ADDR_W = 5,
  parameter int N_CTRL = 6
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                sdi,
  input  logic                sdifs,
  output logic                sdo,
  output logic                sdofs,
  input  logic                smp_vld,
  input  logic                smp_sel,
  input  logic [W-1:0]        smp_data,
  output logic [N_CTRL*W-1:0] ctrl_regs,
  output logic [W-1:0]        dac_word,
  output logic                dac_stb,
  output logic [W-1:0]        filt_word,
  output logic                filt_stb
);
  localparam int CW = $clog2(W);
  localparam int PW = $clog2(2*W);
  localparam logic [ADDR_W-1:0] A_DAC  = ADDR_W'(N_CTRL);
  localparam logic [ADDR_W-1:0] A_FLT  = ADDR_W'(N_CTRL + 1);
  localparam logic [ADDR_W-1:0] A_SMP0 = ADDR_W'(N_CTRL + 2);
  localparam logic [ADDR_W-1:0] A_SMP1 = ADDR_W'(N_CTRL + 3);

  // receive side, falling edge
  logic              rx_act, rx_ph, rx_rd, rd_tgl;
  logic [CW-1:0]     rx_cnt;
  logic [W-2:0]      rx_sr;
  logic [ADDR_W-1:0] rx_a, rd_addr;

  wire         rx_fin  = rx_act && (rx_cnt == CW'(W-1));
  wire [W-1:0] rx_word = {rx_sr, sdi};

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0; rx_ph <= 1'b0; rx_rd <= 1'b0; rd_tgl <= 1'b0;
      rx_cnt <= '0; rx_sr <= '0; rx_a <= '0; rd_addr <= '0;
      ctrl_regs <= '0; dac_word <= '0; filt_word <= '0;
      dac_stb <= 1'b0; filt_stb <= 1'b0;
    end else begin
      dac_stb  <= 1'b0;
      filt_stb <= 1'b0;
      if (!rx_act) begin
        rx_act <= sdifs;
        rx_cnt <= '0;
      end else begin
        rx_sr  <= rx_word[W-2:0];
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_fin) begin
          rx_act <= sdifs;
          rx_cnt <= '0;
          rx_ph  <= !rx_ph;
          if (!rx_ph) begin
            rx_rd <= rx_word[W-1];
            rx_a  <= rx_word[ADDR_W-1:0];
          end else if (rx_rd) begin
            if (rx_a < A_DAC) begin
              rd_tgl  <= ~rd_tgl;
              rd_addr <= rx_a;
            end
          end else if (rx_a < A_DAC) begin
            ctrl_regs[rx_a*W +: W] <= rx_word;
          end else if (rx_a == A_DAC) begin
            dac_word <= rx_word;
            dac_stb  <= 1'b1;
          end else if (rx_a == A_FLT) begin
            filt_word <= rx_word;
            filt_stb  <= 1'b1;
          end
        end
      end
    end
  end

  // transmit side, rising edge
  logic              tx_busy, rd_ack, sb_vld, sb_sel;
  logic [PW-1:0]     tx_cnt;
  logic [2*W-1:0]    tx_sr;
  logic [W-1:0]      sb_data;

  wire              rd_pend  = rd_tgl ^ rd_ack;
  wire              tx_start = !tx_busy && (rd_pend || sb_vld);
  wire              take_smp = tx_start && !rd_pend;
  wire [ADDR_W-1:0] sb_a     = sb_sel ? A_SMP1 : A_SMP0;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; rd_ack <= 1'b0; sb_vld <= 1'b0; sb_sel <= 1'b0;
      tx_cnt <= '0; tx_sr <= '0; sb_data <= '0;
      sdo <= 1'b0; sdofs <= 1'b0;
    end else begin
      if (smp_vld) begin
        sb_vld  <= 1'b1;
        sb_sel  <= smp_sel;
        sb_data <= smp_data;
      end else if (take_smp) begin
        sb_vld <= 1'b0;
      end
      sdo   <= 1'b0;
      sdofs <= 1'b0;
      if (tx_start) begin
        tx_busy <= 1'b1;
        tx_cnt  <= '0;
        sdofs   <= 1'b1;
        if (rd_pend) begin
          rd_ack <= rd_tgl;
          tx_sr  <= {{(W-ADDR_W){1'b0}}, rd_addr, ctrl_regs[rd_addr*W +: W]};
        end else begin
          tx_sr  <= {{(W-ADDR_W){1'b0}}, sb_a, sb_data};
        end
      end else if (tx_busy) begin
        sdo    <= tx_sr[2*W-1];
        tx_sr  <= tx_sr << 1;
        sdofs  <= (tx_cnt == PW'(W-1));
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == PW'(2*W-1)) tx_busy <= 1'b0;
      end
    end
  end

  AST_TXFS_PULSE: assert property (@(posedge sclk) disable iff (!rst_n)
    sdofs |=> !sdofs); // R11
  AST_DAC_STB_PULSE: assert property (@(negedge sclk) disable iff (!rst_n)
    dac_stb |=> !dac_stb); // R3
  AST_CTRL_HOLD: assert property (@(negedge sclk) disable iff (!rst_n)
    !(rx_fin && rx_ph) |=> $stable(ctrl_regs)); // R2
  AST_SBUF_KEEP: assert property (@(posedge sclk) disable iff (!rst_n)
    (tx_start && rd_pend && sb_vld) |=> sb_vld); // R9
endmodule

// File: tb/serial_regport_tb_top.sv
`timescale 1ns/1ps
module serial_regport_tb_top;
  logic        sclk = 1'b0, rst_n = 1'b0;
  logic        sdi = 1'b0, sdifs = 1'b0, sdo, sdofs;
  logic        smp_vld = 1'b0, smp_sel = 1'b0;
  logic [15:0] smp_data = '0;
  logic [95:0] ctrl_regs;
  logic [15:0] dac_word, filt_word;
  logic        dac_stb, filt_stb;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] exp_ctrl [6];
  bit          chained = 0;

  always #2.5 sclk = ~sclk;

  serial_regport dut_i (
    .sclk(sclk), .rst_n(rst_n), .sdi(sdi), .sdifs(sdifs), .sdo(sdo), .sdofs(sdofs),
    .smp_vld(smp_vld), .smp_sel(smp_sel), .smp_data(smp_data),
    .ctrl_regs(ctrl_regs), .dac_word(dac_word), .dac_stb(dac_stb),
    .filt_word(filt_word), .filt_stb(filt_stb));

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic slot(input logic fs, input logic d);
    @(posedge sclk); #1; sdifs = fs; sdi = d;
  endtask

  task automatic hword(input logic [15:0] w, input bit fs_last, input int glitch);
    if (!chained) slot(1'b1, 1'b0);
    for (int i = 15; i >= 0; i--) slot((i == 0 && fs_last) || (15 - i == glitch), w[i]);
    chained = fs_last;
  endtask

  task automatic hpair(input logic [15:0] a, input logic [15:0] d);
    hword(a, 1, -1);
    hword(d, 0, -1);
  endtask

  task automatic settle();
    @(negedge sclk); #1;
  endtask

  task automatic expect_pair(input logic [15:0] a, input logic [15:0] d, input string tag);
    exp_q.push_back(a); tag_q.push_back(tag);
    exp_q.push_back(d); tag_q.push_back(tag);
  endtask

  task automatic sample(input logic sel, input logic [15:0] d);
    @(posedge sclk); #1; smp_vld = 1'b1; smp_sel = sel; smp_data = d;
    @(posedge sclk); #1; smp_vld = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (120) @(posedge sclk);
    check(req, 96'(exp_q.size()), 96'd0);
  endtask

  function automatic logic [95:0] ctrl_model();
    logic [95:0] v;
    for (int k = 0; k < 6; k++) v[k*16 +: 16] = exp_ctrl[k];
    return v;
  endfunction

  // scoreboard monitor: decode transmit stream, compare against queue
  bit          m_act = 0, m_bad = 0;
  int          m_cnt = 0;
  logic [15:0] m_w = '0;
  always begin
    @(negedge sclk); #1;
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_bad = 0;
    end else if (!m_act) begin
      if (sdofs) begin m_act = 1; m_cnt = 0; m_bad = 0; end
    end else begin
      if (sdofs && m_cnt != 15) m_bad = 1;
      m_w = {m_w[14:0], sdo};
      m_cnt++;
      if (m_cnt == 16) begin
        check("R11 frame sync placement", 96'(m_bad), 96'd0);
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4/R6 unexpected word act=%h exp=none", m_w);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (m_w !== e) begin
            fails++;
            $display("FAIL %s tx word act=%h exp=%h", t, m_w, e);
          end
        end
        m_act = sdofs; m_cnt = 0; m_bad = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge sclk);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements) act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) exp_ctrl[k] = '0;
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1 sdo", 96'(sdo), 96'd0);
    check("R1 sdofs", 96'(sdofs), 96'd0);
    check("R1 ctrl", ctrl_regs, 96'd0);
    check("R1 dac/filt", {64'd0, dac_word, filt_word}, 96'd0);

    // R2 commit only after the data word
    hword(16'h0000, 1, -1);
    settle();
    check("R2 after address only", 96'(ctrl_regs[15:0]), 96'd0);
    hword(16'hA5C3, 0, -1);
    settle();
    exp_ctrl[0] = 16'hA5C3;
    check("R2 slot0", ctrl_regs, ctrl_model());
    hpair(16'h0003, 16'h1234); settle(); exp_ctrl[3] = 16'h1234;
    hpair(16'h0005, 16'hBEEF); settle(); exp_ctrl[5] = 16'hBEEF;
    check("R2 slots 3,5", ctrl_regs, ctrl_model());
    // R2 gap-framed pair
    hword(16'h0002, 0, -1);
    repeat (3) slot(1'b0, 1'b0);
    hword(16'h1111, 0, -1); settle(); exp_ctrl[2] = 16'h1111;
    check("R2 gap-framed pair", ctrl_regs, ctrl_model());

    // R3 data slots and strobes
    hpair(16'h0006, 16'h7E01); settle();
    check("R3 dac_word", 96'(dac_word), 96'h7E01);
    check("R3 dac_stb high", 96'(dac_stb), 96'd1);
    settle();
    check("R3 dac_stb low", 96'(dac_stb), 96'd0);
    hpair(16'h0007, 16'h0F0F); settle();
    check("R3 filt_word", 96'(filt_word), 96'h0F0F);
    check("R3 filt_stb high", 96'(filt_stb), 96'd1);
    settle();
    check("R3 filt_stb low", 96'(filt_stb), 96'd0);

    // R4 writes to read-only and reserved slots
    hpair(16'h0008, 16'hFFFF);
    hpair(16'h0009, 16'hFFFF);
    hpair(16'h001F, 16'hFFFF);
    hpair(16'h000A, 16'hFFFF); settle();
    check("R4 ctrl unchanged", ctrl_regs, ctrl_model());
    check("R4 data slots unchanged", {64'd0, dac_word, filt_word}, {64'd0, 16'h7E01, 16'h0F0F});
    drain("R4 no transmission");

    // R10 chained words with mid-word frame sync
    hword(16'h0001, 1, 3);
    hword(16'h4242, 0, 7); settle(); exp_ctrl[1] = 16'h4242;
    check("R10 mid-word sync ignored", ctrl_regs, ctrl_model());

    // R5 control reads
    expect_pair(16'h0003, 16'h1234, "R5 read slot3");
    hpair(16'h8003, 16'hDEAD);
    drain("R5 reply slot3");
    expect_pair(16'h0001, 16'h4242, "R5 read slot1");
    hpair(16'h8001, 16'h0000);
    drain("R5 reply slot1");

    // R6 reads of non-control slots
    hpair(16'h8006, 16'h0000);
    hpair(16'h8009, 16'h0000);
    hpair(16'h801F, 16'h0000);
    drain("R6 no reply");

    // R7 device samples
    expect_pair(16'h0008, 16'h1357, "R7 sample sel0");
    sample(1'b0, 16'h1357);
    drain("R7 sel0");
    expect_pair(16'h0009, 16'hFEDC, "R7 sample sel1");
    sample(1'b1, 16'hFEDC);
    drain("R7 sel1");

    // R8 / R9 reply waits, then goes before buffered sample; newer sample wins
    expect_pair(16'h0008, 16'hAAAA, "R8 in-progress pair first");
    expect_pair(16'h0005, 16'hBEEF, "R9 reply before sample");
    expect_pair(16'h0009, 16'hCCCC, "R9 newest sample kept");
    fork
      hpair(16'h8005, 16'h0000);
      begin
        repeat (2) @(posedge sclk);
        sample(1'b0, 16'hAAAA);
        repeat (12) @(posedge sclk);
        sample(1'b1, 16'hBBBB);
        repeat (3) @(posedge sclk);
        sample(1'b1, 16'hCCCC);
      end
    join
    drain("R8/R9 ordering");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule